// File: doc/BRIEF.md
# Direct-Mapped Cache with Two-Stage Pipelined Stores

This block is a direct-mapped, one-word-per-line cache whose stores take two slots. In the slot where a store is accepted, only its tag is compared against the tag array. A store that hits is parked in a single-entry delayed store register, together with its address and byte enables. The data array is single-ported, so the parked bytes are written into it later, in the next slot that does not read the array: the tag-check slot of the following store, a store that misses, or an idle slot. As a result, two stores in a row each cost one slot. Reads never wait for the commit. Each read compares its address with the parked entry and takes the parked bytes in place of the array bytes.

A store that misses leaves the cache unchanged. It is handed to a separate write path toward lower memory as a one-cycle pulse that carries its address, data and byte enables. Refills come back on their own port. A refill installs a whole line and takes the array for that slot. Every request gets its response one cycle after it is presented. That response is either a hit with data or a miss flag.

Top module: `pipe_wr_cache`

## Requirements
- R1: After reset every line is invalid, so every access misses until its line is refilled, and `rsp_valid` and `wmiss_valid` are low until the first request.
- R2: The word address splits into an index (the low INDEX_W bits) and a tag (the remaining upper bits). One cycle after a read, `rsp_valid` is 1. If the line at that index is valid and its tag matches, `rsp_hit`=1, `rsp_miss`=0 and `rsp_rdata` holds the newest word. Otherwise `rsp_hit`=0, `rsp_miss`=1 and `rsp_rdata`=0.
- R3: A store that hits answers with `rsp_hit`=1 and `rsp_rdata`=0 one cycle later and is parked. The parked bytes reach the array no later than the next slot that is not a read, and a later store to another index never loses them.
- R4: With no further store, a parked entry is written to the array in the first idle slot. A read slot never writes the array and leaves the parked entry in place.
- R5: A read whose full address equals the parked address returns the parked bytes merged over the array bytes, byte by byte.
- R6: Byte-enable bit i selects data bits 8i+7 down to 8i. Only enabled bytes of a store change the cached word.
- R7: A store that misses does not change the cache. One cycle later it answers with `rsp_miss`=1 and pulses `wmiss_valid` for one cycle, with `wmiss_addr`, `wmiss_data` and `wmiss_be` equal to the store's values.
- R8: A refill marks its line valid with the refill tag and writes the whole word. A request presented in the same cycle as a refill is dropped and gets no response. A refill to the index of the parked entry cancels that entry.
- R9: Back-to-back stores to the same address keep program order. A read returns the last store's enabled bytes over the earlier store's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | ADDR_W | Word address (tag above index) |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| fill_valid | input | 1 | Refill of one line from lower memory |
| fill_addr | input | ADDR_W | Refill word address |
| fill_data | input | DATA_W | Refill word |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_hit | output | 1 | Request hit |
| rsp_miss | output | 1 | Request missed |
| rsp_rdata | output | DATA_W | Read data on a read hit, else 0 |
| wmiss_valid | output | 1 | Store miss handed toward lower memory |
| wmiss_addr | output | ADDR_W | Address of the missed store |
| wmiss_data | output | DATA_W | Data of the missed store |
| wmiss_be | output | DATA_W/8 | Byte enables of the missed store |

## Verification
The parked entry is the only state that the array does not show, so any fault in it appears on `rsp_rdata`. The fault may be a lost commit, a commit in a read slot, a wrong byte merge or a failed cancel on refill. It shows on the first read to that address after the parked entry is replaced or bypassed, which is often the very next cycle. Tag-array faults show one cycle after the next access to that index, as a flipped `rsp_hit`, or as a `wmiss_valid` pulse that is missing or spurious. The bench therefore mixes long random runs over few tags and indexes with directed pairs that put a read or a refill right after a store.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    // Kind of slot, decided once per cycle by the top
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_STORE = 2'd2,
        CYC_FILL  = 2'd3
    } cyc_e;

endpackage

// File: rtl/pwc_tag_store.sv
module pwc_tag_store #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [INDEX_W-1:0] look_idx,
    input  logic [TAG_W-1:0]   look_tag,
    output logic               look_hit
);
    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tags_t;

    tags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_idx] = 1'b1;
            st_d.tag[fill_idx] = fill_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign look_hit = st_q.vld[look_idx] && (st_q.tag[look_idx] == look_tag);

    // R8: a refill leaves its line valid with the refill tag
    a_r8_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.vld[$past(fill_idx)] && st_q.tag[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/pwc_data_store.sv
module pwc_data_store #(
    parameter int INDEX_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [INDEX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W/8-1:0]  wr_be,
    input  logic [INDEX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int LINES = 1 << INDEX_W;
    localparam int BYTES = DATA_W / 8;

    logic [LINES-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) mem_d[wr_idx][8*b +: 8] = wr_data[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];

    // R6: an enabled low byte lands in the addressed word
    a_r6_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0]) |=> (mem_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));

endmodule

// File: rtl/pwc_delay_wbuf.sv
module pwc_delay_wbuf #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [ADDR_W-1:0]   cap_addr,
    input  logic [DATA_W-1:0]   cap_data,
    input  logic [DATA_W/8-1:0] cap_be,
    input  logic                port_free,
    input  logic                fill_en,
    input  logic [INDEX_W-1:0]  fill_idx,
    input  logic [ADDR_W-1:0]   probe_addr,
    output logic [DATA_W/8-1:0] probe_be,
    output logic [DATA_W-1:0]   buf_data,
    output logic                commit_en,
    output logic [INDEX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0]   commit_data,
    output logic [DATA_W/8-1:0] commit_be
);
    localparam int BYTES = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  be;
    } park_t;

    park_t pk_d, pk_q;
    logic  cancel;

    assign cancel    = fill_en && pk_q.vld && (pk_q.addr[INDEX_W-1:0] == fill_idx);
    assign commit_en = pk_q.vld && port_free;

    always_comb begin
        pk_d = pk_q;
        if (cancel) begin
            pk_d.vld = 1'b0;
        end else if (cap_en) begin
            pk_d.vld  = 1'b1;
            pk_d.addr = cap_addr;
            pk_d.data = cap_data;
            pk_d.be   = cap_be;
        end else if (commit_en) begin
            pk_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign probe_be    = (pk_q.vld && pk_q.addr == probe_addr) ? pk_q.be : '0;
    assign buf_data    = pk_q.data;
    assign commit_idx  = pk_q.addr[INDEX_W-1:0];
    assign commit_data = pk_q.data;
    assign commit_be   = pk_q.be;

    // R3: a store hit is parked at its own address
    a_r3_hit_parks: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (pk_q.vld && pk_q.addr == $past(cap_addr)));

    // R4: a read slot keeps the parked entry untouched
    a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.vld && !port_free && !fill_en) |=> (pk_q.vld && $stable(pk_q.addr) && $stable(pk_q.data)));

    // R4: an idle slot drains the parked entry
    a_r4_idle_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.vld && port_free && !cap_en && !fill_en) |=> !pk_q.vld);

    // R8: a refill to the parked index cancels it
    a_r8_fill_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && pk_q.vld && pk_q.addr[INDEX_W-1:0] == fill_idx) |=> !pk_q.vld);

endmodule

// File: rtl/pipe_wr_cache.sv
module pipe_wr_cache
    import pwc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic                fill_valid,
    input  logic [ADDR_W-1:0]   fill_addr,
    input  logic [DATA_W-1:0]   fill_data,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                wmiss_valid,
    output logic [ADDR_W-1:0]   wmiss_addr,
    output logic [DATA_W-1:0]   wmiss_data,
    output logic [DATA_W/8-1:0] wmiss_be
);
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int BYTES = DATA_W / 8;

    cyc_e cyc;

    always_comb begin
        if (fill_valid)                  cyc = CYC_FILL;
        else if (req_valid && req_write) cyc = CYC_STORE;
        else if (req_valid)              cyc = CYC_READ;
        else                             cyc = CYC_IDLE;
    end

    logic [INDEX_W-1:0] look_idx;
    logic [TAG_W-1:0]   look_tag;
    logic               look_hit;

    assign look_idx = req_addr[INDEX_W-1:0];
    assign look_tag = req_addr[ADDR_W-1:INDEX_W];

    pwc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_idx (fill_addr[INDEX_W-1:0]),
        .fill_tag (fill_addr[ADDR_W-1:INDEX_W]),
        .look_idx (look_idx),
        .look_tag (look_tag),
        .look_hit (look_hit)
    );

    logic               cap_en, port_free, commit_en;
    logic [BYTES-1:0]   probe_be, commit_be;
    logic [DATA_W-1:0]  buf_data, commit_data;
    logic [INDEX_W-1:0] commit_idx;

    assign cap_en    = (cyc == CYC_STORE) && look_hit;
    assign port_free = (cyc == CYC_STORE) || (cyc == CYC_IDLE);

    pwc_delay_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_park (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cap_addr    (req_addr),
        .cap_data    (req_wdata),
        .cap_be      (req_be),
        .port_free   (port_free),
        .fill_en     (fill_valid),
        .fill_idx    (fill_addr[INDEX_W-1:0]),
        .probe_addr  (req_addr),
        .probe_be    (probe_be),
        .buf_data    (buf_data),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .commit_be   (commit_be)
    );

    // Single array port: a refill owns it, otherwise a commit may use it
    logic               ds_we;
    logic [INDEX_W-1:0] ds_idx;
    logic [DATA_W-1:0]  ds_data, arr_word, merged;
    logic [BYTES-1:0]   ds_be;

    assign ds_we   = fill_valid || commit_en;
    assign ds_idx  = fill_valid ? fill_addr[INDEX_W-1:0] : commit_idx;
    assign ds_data = fill_valid ? fill_data : commit_data;
    assign ds_be   = fill_valid ? {BYTES{1'b1}} : commit_be;

    pwc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ds_we),
        .wr_idx  (ds_idx),
        .wr_data (ds_data),
        .wr_be   (ds_be),
        .rd_idx  (look_idx),
        .rd_data (arr_word)
    );

    // Parked bytes override array bytes on an address match
    for (genvar gb = 0; gb < BYTES; gb++) begin : g_merge
        assign merged[8*gb +: 8] = probe_be[gb] ? buf_data[8*gb +: 8] : arr_word[8*gb +: 8];
    end

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [DATA_W-1:0] rdata;
        logic              wm_valid;
        logic [ADDR_W-1:0] wm_addr;
        logic [DATA_W-1:0] wm_data;
        logic [BYTES-1:0]  wm_be;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d = '0;
        case (cyc)
            CYC_READ: begin
                r_d.valid = 1'b1;
                r_d.hit   = look_hit;
                r_d.miss  = !look_hit;
                r_d.rdata = look_hit ? merged : '0;
            end
            CYC_STORE: begin
                r_d.valid = 1'b1;
                r_d.hit   = look_hit;
                r_d.miss  = !look_hit;
                if (!look_hit) begin
                    r_d.wm_valid = 1'b1;
                    r_d.wm_addr  = req_addr;
                    r_d.wm_data  = req_wdata;
                    r_d.wm_be    = req_be;
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid   = r_q.valid;
    assign rsp_hit     = r_q.hit;
    assign rsp_miss    = r_q.miss;
    assign rsp_rdata   = r_q.rdata;
    assign wmiss_valid = r_q.wm_valid;
    assign wmiss_addr  = r_q.wm_addr;
    assign wmiss_data  = r_q.wm_data;
    assign wmiss_be    = r_q.wm_be;

    // R2: every request outside a refill slot is answered next cycle
    a_r2_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fill_valid) |=> rsp_valid);

    // R8: a request beside a refill is dropped
    a_r8_fill_drops: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!rsp_valid && !wmiss_valid));

    // R7: a missing store goes out on the miss path with its address
    a_r7_miss_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !fill_valid && !look_hit)
            |=> (wmiss_valid && rsp_miss && wmiss_addr == $past(req_addr)));

    // R3: a store hit never reaches the miss path
    a_r3_hit_stays: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (rsp_hit && !wmiss_valid));

endmodule

// File: tb/pipe_wr_cache_bench.sv
module pipe_wr_cache_bench;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int INDEX_W = 4;
    localparam int LINES   = 1 << INDEX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        fill_valid = 1'b0;
    logic [11:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, wmiss_valid;
    logic [31:0] rsp_rdata, wmiss_data;
    logic [11:0] wmiss_addr;
    logic [3:0]  wmiss_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state: the newest architectural view of each line
    bit          mv [LINES];
    logic [7:0]  mt [LINES];
    logic [31:0] md [LINES];

    always #5 clk = ~clk;

    pipe_wr_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_pipe_wr_cache (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_be (req_be),
        .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_data (fill_data),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss), .rsp_rdata (rsp_rdata),
        .wmiss_valid (wmiss_valid), .wmiss_addr (wmiss_addr), .wmiss_data (wmiss_data),
        .wmiss_be (wmiss_be)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_bytes(input logic [31:0] old, input logic [31:0] nw,
                                                input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // One slot: drive at a falling edge, check the registered response one cycle later
    task automatic step(input logic rv, input logic rw, input logic [11:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic fv, input logic [11:0] fa,
                        input logic [31:0] fd, input string tag);
        logic [63:0] e_rsp = '0;
        logic [63:0] e_wm  = '0;
        int idx;
        bit h;
        req_valid = rv; req_write = rw; req_addr = a; req_wdata = wd; req_be = be;
        fill_valid = fv; fill_addr = fa; fill_data = fd;
        if (fv) begin
            mv[fa[3:0]] = 1'b1;
            mt[fa[3:0]] = fa[11:4];
            md[fa[3:0]] = fd;
        end else if (rv) begin
            idx = int'(a[3:0]);
            h = mv[idx] && (mt[idx] == a[11:4]);
            if (!rw) begin
                e_rsp = {29'b0, 1'b1, h, !h, (h ? md[idx] : 32'h0)};
            end else begin
                e_rsp = {29'b0, 1'b1, h, !h, 32'h0};
                if (h) md[idx] = merge_bytes(md[idx], wd, be);
                else   e_wm = {15'b0, 1'b1, a, wd, be};
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {29'b0, rsp_valid, rsp_hit, rsp_miss, rsp_rdata}, e_rsp);
        check(tag, wmiss_valid ? {15'b0, 1'b1, wmiss_addr, wmiss_data, wmiss_be} : 64'h0, e_wm);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 12'h0, 32'h0, 4'h0, 1'b0, 12'h0, 32'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = '0; md[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check("R1 reset", {62'b0, rsp_valid, wmiss_valid}, 64'h0);
        // R1: empty cache misses
        step(1, 0, 12'h013, 0, 0, 0, 0, 0, "R1 cold read");
        step(0, 0, 0, 0, 0, 1, 12'h013, 32'hA1B2C3D4, "R8 refill");
        step(1, 0, 12'h013, 0, 0, 0, 0, 0, "R2 read hit");
        step(1, 1, 12'h013, 32'h11223344, 4'b0011, 0, 0, 0, "R6 partial store");
        step(1, 0, 12'h013, 0, 0, 0, 0, 0, "R5 forward merge");
        step(1, 1, 12'h013, 32'h55667788, 4'b1100, 0, 0, 0, "R9 second store");
        step(1, 0, 12'h013, 0, 0, 0, 0, 0, "R9 order kept");
        idle("R4 idle slot");
        step(1, 0, 12'h013, 0, 0, 0, 0, 0, "R4 after drain");
        step(0, 0, 0, 0, 0, 1, 12'h025, 32'h0BADF00D, "R8 refill B");
        step(1, 1, 12'h025, 32'hCAFEBABE, 4'b1111, 0, 0, 0, "R3 store hit B");
        step(1, 1, 12'h0F7, 32'hDEAD0001, 4'b0101, 0, 0, 0, "R7 store miss");
        step(1, 0, 12'h025, 0, 0, 0, 0, 0, "R3 committed B");
        step(1, 0, 12'h0F7, 0, 0, 0, 0, 0, "R7 cache unchanged");
        step(1, 0, 12'h013, 0, 0, 1, 12'h02A, 32'h12345678, "R8 request dropped");
        step(1, 0, 12'h02A, 0, 0, 0, 0, 0, "R8 refill visible");
        step(1, 1, 12'h025, 32'h77777777, 4'b1111, 0, 0, 0, "R3 park B");
        step(0, 0, 0, 0, 0, 1, 12'h035, 32'h99990000, "R8 refill over parked");
        step(1, 0, 12'h035, 0, 0, 0, 0, 0, "R8 cancel new line");
        step(1, 0, 12'h025, 0, 0, 0, 0, 0, "R8 cancel old line");
        // Random mix over three tags to force hits, misses and conflicts
        for (int n = 0; n < 3000; n++) begin
            int k = int'($urandom % 8);
            logic [11:0] a = {6'b0, 2'($urandom % 3), 4'($urandom)};
            logic [31:0] d = $urandom;
            logic [3:0]  be = 4'($urandom);
            if (k == 0)      idle("R4 random idle");
            else if (k < 4)  step(1, 0, a, 0, 0, 0, 0, 0, "R5 random read");
            else if (k < 7)  step(1, 1, a, d, be, 0, 0, 0, "R6 random store");
            else             step(0, 0, 0, 0, 0, 1, a, d, "R8 random refill");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule